// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block is the control core of one DMA channel. It keeps a source address, a destination address and a 16-bit transfer count. Each time the surrounding controller reports a finished transfer with a one-cycle strobe, the block advances these registers according to the channel's settings. Addresses can stay fixed or can step by the transfer unit, which is one byte or two bytes. A channel runs in one of two modes. Normal mode stops when the count underflows. Ring mode cycles over 32 transfers until software stops it.

Software loads the addresses and the count while the channel is idle, then sets the enable bit. When a normal-mode run reaches its end, hardware clears enable, leaves the count at all-ones and raises a sticky interrupt request unless it is masked. Ring mode never raises that request. Bus signalling, arbitration between channels and the data path sit outside this block.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset both addresses and the count read 0, enable reads 0 and the interrupt request reads 0.
- R2: Writes to the source, destination or count register are accepted only while enable is 0. A write made while enable is 1 leaves the register unchanged.
- R3: A transfer strobe that arrives while enable is 0 changes no address, count or flag.
- R4: In normal mode every accepted transfer decrements the count. A transfer accepted while the count is 0 ends the run: the count becomes 0xFFFF and enable becomes 0. A programmed count N therefore gives N+1 transfers, and 0xFFFF gives 65,536 transfers.
- R5: When a normal-mode run ends and the mask input is 0, the interrupt request goes to 1 and stays there. When the mask input is 1, the request stays 0.
- R6: A clear strobe sets the interrupt request to 0. If a clear and a completion fall in the same cycle, the request is 1.
- R7: An address whose increment select is 0 keeps its value during and after the run.
- R8: An address whose increment select is 1 grows by 1 per transfer when the wide-unit input is 0 and by 2 when it is 1. After the run ends it holds the last transfer address plus that step.
- R9: In ring mode the count decrements and wraps freely and enable stays 1. An incrementing address returns to the value it had when enable was set after every 32 transfers; this holds for any start alignment.
- R10: Ring mode never raises the interrupt request, including when software clears enable.
- R11: An enable-set strobe sets enable only when it is 0. An enable-clear strobe clears it, and wins over a set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_src | input | 1 | Load source address from wr_data |
| wr_dst | input | 1 | Load destination address from wr_data |
| wr_cnt | input | 1 | Load count from the low bits of wr_data |
| wr_data | input | AW | Software write data |
| ring_mode | input | 1 | 0 normal, 1 ring of 32 transfers |
| src_inc | input | 1 | Source address increments when 1 |
| dst_inc | input | 1 | Destination address increments when 1 |
| wide_unit | input | 1 | 0 byte unit, 1 two-byte unit |
| irq_mask | input | 1 | Suppresses the completion request when 1 |
| en_set | input | 1 | Enable-set strobe |
| en_clr | input | 1 | Enable-clear strobe |
| irq_clr | input | 1 | Interrupt clear strobe |
| xfer_done | input | 1 | One-cycle transfer-finished strobe |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| xfer_count | output | CW | Current transfer count |
| chan_enable | output | 1 | Channel enable bit |
| irq_req | output | 1 | Sticky completion interrupt request |

## Verification
Several rules are checked by assertions on every cycle. These are the underflow to all-ones with enable dropping, the single-step address increment, fixed addresses holding, the ring wrap reloading the latched start, the disabled channel holding its state, clear beating set, and the absence of a request in ring mode or under mask. Some behaviour only shows up over a whole run, and only the bench scenarios can show it. This covers the exact N+1 transfer total including the 65,536-transfer case, the 32-step return to a misaligned start, and the interaction of completion with a simultaneous clear. A behavioural model in the bench is compared against every output each cycle.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic {RUN_NORMAL = 1'b0, RUN_RING = 1'b1} run_mode_e;

  function automatic logic [2:0] unit_bytes(input logic wide);
    return wide ? 3'd2 : 3'd1;
  endfunction
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  input  logic          latch_start,
  input  logic          step_en,
  input  logic          inc,
  input  logic          wide,
  input  logic          wrap,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_q;
  logic [AW-1:0] start_q;
  logic [AW-1:0] step;

  assign step = AW'(unit_bytes(wide));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      start_q <= '0;
    end else begin
      if (latch_start) start_q <= addr_q;
      if (wr_en) begin
        addr_q <= wr_data;
      end else if (step_en && inc) begin
        addr_q <= wrap ? start_q : addr_q + step;
      end
    end
  end

  assign addr = addr_q;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (step_en && inc && !wrap && !wr_en) |=> (addr_q == $past(addr_q) + $past(step))); // R8
  AST_ADDR_FIXED: assert property (@(posedge clk) disable iff (rst)
    (step_en && !inc && !wr_en) |=> $stable(addr_q)); // R7
  AST_RING_RETURN: assert property (@(posedge clk) disable iff (rst)
    (step_en && inc && wrap && !wr_en) |=> (addr_q == $past(start_q))); // R9
endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          step_en,
  output logic [CW-1:0] count,
  output logic          at_zero
);
  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (wr_en) begin
      count_q <= wr_data;
    end else if (step_en) begin
      count_q <= count_q - 1'b1;
    end
  end

  assign count   = count_q;
  assign at_zero = (count_q == '0);

  AST_COUNT_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (step_en && at_zero && !wr_en) |=> (count_q == {CW{1'b1}})); // R4
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_seq_pkg::*;
#(
  parameter int RING_LEN = 32
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en_set,
  input  logic      en_clr,
  input  logic      xfer_done,
  input  run_mode_e mode,
  input  logic      irq_mask,
  input  logic      irq_clr,
  input  logic      cnt_zero,
  output logic      enable,
  output logic      irq,
  output logic      xfer_ok,
  output logic      start,
  output logic      wrap
);
  localparam int IW = (RING_LEN > 1) ? $clog2(RING_LEN) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(RING_LEN - 1);

  logic          en_q;
  logic          irq_q;
  logic [IW-1:0] idx_q;
  logic          done;

  assign xfer_ok = xfer_done && en_q;
  assign start   = en_set && !en_clr && !en_q;
  assign done    = xfer_ok && (mode == RUN_NORMAL) && cnt_zero;
  assign wrap    = xfer_ok && (mode == RUN_RING) && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
      idx_q <= '0;
    end else begin
      if (en_clr || done)  en_q <= 1'b0;
      else if (start)      en_q <= 1'b1;

      if (done && !irq_mask) irq_q <= 1'b1;
      else if (irq_clr)      irq_q <= 1'b0;

      if (start)        idx_q <= '0;
      else if (wrap)    idx_q <= '0;
      else if (xfer_ok) idx_q <= idx_q + 1'b1;
    end
  end

  assign enable = en_q;
  assign irq    = irq_q;

  AST_NORMAL_STOP: assert property (@(posedge clk) disable iff (rst)
    done |=> !en_q); // R4
  AST_IRQ_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
    (done && !irq_mask) |=> irq_q); // R6
  AST_RING_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (!irq_q && (mode == RUN_RING)) |=> !irq_q); // R10
  AST_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (!irq_q && irq_mask) |=> !irq_q); // R5
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    en_clr |=> !en_q); // R11
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int AW       = 32,
  parameter int CW       = 16,
  parameter int RING_LEN = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_src,
  input  logic          wr_dst,
  input  logic          wr_cnt,
  input  logic [AW-1:0] wr_data,
  input  logic          ring_mode,
  input  logic          src_inc,
  input  logic          dst_inc,
  input  logic          wide_unit,
  input  logic          irq_mask,
  input  logic          en_set,
  input  logic          en_clr,
  input  logic          irq_clr,
  input  logic          xfer_done,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [CW-1:0] xfer_count,
  output logic          chan_enable,
  output logic          irq_req
);
  localparam int NPTR = 2;

  run_mode_e     mode;
  logic          en;
  logic          xfer_ok;
  logic          start;
  logic          wrap;
  logic          cnt_zero;
  logic [NPTR-1:0] ptr_wr;
  logic [NPTR-1:0] ptr_inc;
  logic [AW-1:0] ptr_addr [NPTR];

  assign mode    = run_mode_e'(ring_mode);
  assign ptr_wr  = {wr_dst && !en, wr_src && !en};
  assign ptr_inc = {dst_inc, src_inc};

  dma_chan_ctrl #(.RING_LEN(RING_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .en_set(en_set), .en_clr(en_clr),
    .xfer_done(xfer_done), .mode(mode), .irq_mask(irq_mask),
    .irq_clr(irq_clr), .cnt_zero(cnt_zero), .enable(en), .irq(irq_req),
    .xfer_ok(xfer_ok), .start(start), .wrap(wrap)
  );

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    dma_addr_unit #(.AW(AW)) u_addr (
      .clk(clk), .rst(rst), .wr_en(ptr_wr[p]), .wr_data(wr_data),
      .latch_start(start), .step_en(xfer_ok), .inc(ptr_inc[p]),
      .wide(wide_unit), .wrap(wrap), .addr(ptr_addr[p])
    );
  end

  dma_count_unit #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .wr_en(wr_cnt && !en), .wr_data(wr_data[CW-1:0]),
    .step_en(xfer_ok), .count(xfer_count), .at_zero(cnt_zero)
  );

  assign src_addr    = ptr_addr[0];
  assign dst_addr    = ptr_addr[1];
  assign chan_enable = en;

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (chan_enable && !xfer_done && (wr_src || wr_dst || wr_cnt))
      |=> ($stable(src_addr) && $stable(dst_addr) && $stable(xfer_count))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!chan_enable && !wr_src && !wr_dst && !wr_cnt)
      |=> ($stable(src_addr) && $stable(dst_addr) && $stable(xfer_count))); // R3
  AST_RING_KEEPS_EN: assert property (@(posedge clk) disable iff (rst)
    (chan_enable && ring_mode && !en_clr) |=> chan_enable); // R9
endmodule

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_src = 0, wr_dst = 0, wr_cnt = 0;
  logic [31:0] wr_data = '0;
  logic        ring_mode = 0, src_inc = 0, dst_inc = 0, wide_unit = 0, irq_mask = 0;
  logic        en_set = 0, en_clr = 0, irq_clr = 0, xfer_done = 0;
  logic [31:0] src_addr, dst_addr;
  logic [15:0] xfer_count;
  logic        chan_enable, irq_req;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  logic [31:0] m_sbase = '0, m_dbase = '0;
  int          m_k = 0;
  int          m_cnt = 0;
  bit          m_en = 0, m_irq = 0;

  always #2 clk = ~clk;

  dma_chan_seq uut (
    .clk(clk), .rst(rst), .wr_src(wr_src), .wr_dst(wr_dst), .wr_cnt(wr_cnt),
    .wr_data(wr_data), .ring_mode(ring_mode), .src_inc(src_inc), .dst_inc(dst_inc),
    .wide_unit(wide_unit), .irq_mask(irq_mask), .en_set(en_set), .en_clr(en_clr),
    .irq_clr(irq_clr), .xfer_done(xfer_done), .src_addr(src_addr), .dst_addr(dst_addr),
    .xfer_count(xfer_count), .chan_enable(chan_enable), .irq_req(irq_req)
  );

  function automatic logic [31:0] m_addr(input logic [31:0] base, input bit inc);
    int steps;
    steps = ring_mode ? (m_k % 32) : m_k;
    if (!inc) return base;
    return base + 32'(steps * (wide_unit ? 2 : 1));
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit xok, done;
    xok  = xfer_done && m_en;
    done = xok && !ring_mode && (m_cnt == 0);
    if (!m_en && wr_src) m_sbase = wr_data;
    if (!m_en && wr_dst) m_dbase = wr_data;
    if (!m_en && wr_cnt) m_cnt = int'(wr_data[15:0]);
    if (xok) begin
      m_k++;
      m_cnt = (m_cnt + 65535) % 65536;
    end
    if (done && !irq_mask) m_irq = 1;
    else if (irq_clr) m_irq = 0;
    if (en_clr || done) begin
      if (m_en) begin
        m_sbase = m_addr(m_sbase, src_inc);
        m_dbase = m_addr(m_dbase, dst_inc);
        m_k = 0;
      end
      m_en = 0;
    end else if (en_set && !m_en) begin
      m_k  = 0;
      m_en = 1;
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check("R8 src model", src_addr, m_addr(m_sbase, src_inc));
    check("R7 dst model", dst_addr, m_addr(m_dbase, dst_inc));
    check("R4 count model", {16'h0, xfer_count}, 32'(m_cnt));
    check("R11 enable model", {31'h0, chan_enable}, {31'h0, m_en});
    check("R5 irq model", {31'h0, irq_req}, {31'h0, m_irq});
    wr_src = 0; wr_dst = 0; wr_cnt = 0; en_set = 0; en_clr = 0;
    irq_clr = 0; xfer_done = 0;
  endtask

  task automatic load(input logic [31:0] s, input logic [31:0] d, input logic [15:0] c);
    wr_src = 1; wr_data = s; tick();
    wr_dst = 1; wr_data = d; tick();
    wr_cnt = 1; wr_data = {16'h0, c}; tick();
  endtask

  task automatic xfers(input int n, input bit gap);
    for (int i = 0; i < n; i++) begin
      xfer_done = 1; tick();
      if (gap) tick();
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 src", src_addr, 32'h0);
    check("R1 dst", dst_addr, 32'h0);
    check("R1 count", {16'h0, xfer_count}, 32'h0);
    check("R1 enable", {31'h0, chan_enable}, 32'h0);
    check("R1 irq", {31'h0, irq_req}, 32'h0);

    // normal, byte increments on source, fixed destination, count 3
    src_inc = 1; dst_inc = 0; wide_unit = 0;
    load(32'h1000, 32'h2000, 16'd3);
    en_set = 1; tick();
    xfers(4, 1);
    check("R8 src after run", src_addr, 32'h1004);
    check("R7 dst fixed", dst_addr, 32'h2000);
    check("R4 count underflow", {16'h0, xfer_count}, 32'h0000FFFF);
    check("R4 enable cleared", {31'h0, chan_enable}, 32'h0);
    check("R5 irq raised", {31'h0, irq_req}, 32'h1);

    // R3 strobe while idle
    xfer_done = 1; tick();
    check("R3 idle strobe src", src_addr, 32'h1004);
    check("R3 idle strobe count", {16'h0, xfer_count}, 32'h0000FFFF);

    // R6 clear, then R2 write while busy
    irq_clr = 1; tick();
    check("R6 cleared", {31'h0, irq_req}, 32'h0);
    wr_cnt = 1; wr_data = 32'd5; tick();
    en_set = 1; tick();
    wr_src = 1; wr_data = 32'h5555; tick();
    check("R2 busy write ignored", src_addr, 32'h1004);
    xfers(5, 0);
    xfer_done = 1; irq_clr = 1; tick();
    check("R6 set beats clear", {31'h0, irq_req}, 32'h1);
    check("R4 six transfers", src_addr, 32'h100A);
    irq_clr = 1; tick();
    check("R6 clear after", {31'h0, irq_req}, 32'h0);

    // R5 masked completion
    irq_mask = 1;
    wr_cnt = 1; wr_data = 32'd1; tick();
    en_set = 1; tick();
    xfers(2, 0);
    check("R5 masked irq", {31'h0, irq_req}, 32'h0);
    check("R4 masked end", {31'h0, chan_enable}, 32'h0);
    irq_mask = 0;

    // R9 ring, two-byte units
    ring_mode = 1; wide_unit = 1; src_inc = 1; dst_inc = 1;
    load(32'h00801000, 32'h00802000, 16'd2);
    en_set = 1; tick();
    xfers(31, 0);
    check("R9 ring last", src_addr, 32'h0080103E);
    xfer_done = 1; tick();
    check("R9 ring wrap src", src_addr, 32'h00801000);
    check("R9 ring wrap dst", dst_addr, 32'h00802000);
    check("R9 free count", {16'h0, xfer_count}, 32'h0000FFE2);
    check("R9 enable held", {31'h0, chan_enable}, 32'h1);
    check("R10 no ring irq", {31'h0, irq_req}, 32'h0);
    en_clr = 1; tick();
    check("R10 stop no irq", {31'h0, irq_req}, 32'h0);

    // R9 misaligned byte ring
    wide_unit = 0;
    wr_src = 1; wr_data = 32'h1003; tick();
    en_set = 1; tick();
    xfers(20, 1);
    xfers(12, 0);
    check("R9 misaligned wrap", src_addr, 32'h1003);
    xfers(3, 0);
    check("R9 after wrap", src_addr, 32'h1006);
    en_clr = 1; tick();

    // R11 set and clear together
    en_set = 1; en_clr = 1; tick();
    check("R11 clear wins", {31'h0, chan_enable}, 32'h0);
    en_set = 1; tick();
    en_set = 1; tick();
    check("R11 set when idle", {31'h0, chan_enable}, 32'h1);
    en_clr = 1; tick();

    // R4 full 65536-transfer run
    ring_mode = 0;
    load(32'h0, 32'h4000, 16'hFFFF);
    en_set = 1; tick();
    xfers(65535, 0);
    check("R4 before end enable", {31'h0, chan_enable}, 32'h1);
    check("R4 before end count", {16'h0, xfer_count}, 32'h0);
    xfer_done = 1; tick();
    check("R4 full end enable", {31'h0, chan_enable}, 32'h0);
    check("R4 full end src", src_addr, 32'h00010000);
    check("R4 full end count", {16'h0, xfer_count}, 32'h0000FFFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule